// File: doc/BRIEF.md
# Masked Coefficient Bank Copy Engine

This block moves a complete set of filter coefficients from a shadow memory into up to eight working coefficient banks. Software only ever writes the shadow memory. When a synchronisation pulse arrives, the engine reads the shadow memory from the first word to the last, one word per clock. It writes each word, at the same address, into every working bank whose bit is set in an 8-bit destination mask.

Banks that are not selected see no write enable at all. The processing that reads them from its own pointers (four consumers per bank) keeps running on the old coefficients. This allows part of the resources to be taken offline and reloaded while the rest stay in service.

Four per-stage resource counts say how many banks each of four processing stages owns. A copy is only allowed when the four counts add up to at most eight. A sync that arrives with an illegal sum is refused, and an error flag is raised.

Top module: `cbc_copy_engine`

## Requirements
- R1: While reset is low and on the first cycle after it, `busy`, `done`, `cfg_err`, the shadow read enable and all bank write enables are 0.
- R2: A high `sync` sampled while idle, with a legal count sum, starts a copy. Starting at the next cycle, the shadow read port presents addresses 0 to DEPTH-1, one per cycle in rising order, with the read enable high.
- R3: The shadow memory returns data one cycle after the address. In that following cycle, word k is presented on the bank write port at address k with the data read, and the write enable of bank b is high exactly when bit b of the sampled mask is 1.
- R4: A bank whose mask bit is 0 receives no write enable during the copy, and its contents are unchanged.
- R5: The mask is sampled in the cycle the copy starts. Changes to the mask input during a copy have no effect on that copy.
- R6: A `sync` that arrives while `busy` is high is ignored. The copy neither restarts nor lengthens.
- R7: `busy` is high for exactly DEPTH+1 cycles, from the cycle after the accepted sync through the cycle in which the last word is written.
- R8: `done` is a single-cycle pulse in the cycle right after `busy` falls.
- R9: If the four stage counts sum to more than 8, a sync is refused: no copy runs and `cfg_err` goes high. A sum of exactly 8 is legal. An accepted sync clears `cfg_err`.
- R10: Stage s owns bits [4s+3:4s] of `stage_cnt`, read as an unsigned number. A single field above 8 alone makes the sum illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Copy request pulse |
| bank_mask | input | 8 | Destination bank select, bit b for bank b |
| stage_cnt | input | 16 | Four 4-bit per-stage bank counts |
| shadow_rd_en | output | 1 | Shadow memory read enable |
| shadow_rd_addr | output | 10 | Shadow memory read address |
| shadow_rd_data | input | 16 | Shadow read data, one cycle after address |
| bank_wr_en | output | 8 | Per-bank write enable |
| bank_wr_addr | output | 10 | Shared bank write address |
| bank_wr_data | output | 16 | Shared bank write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| cfg_err | output | 1 | Last sync refused for an illegal count sum |

## Verification
Random masks are combined with freshly randomised shadow contents and with banks that already hold earlier data. Comparing every word of every bank therefore separates words that were really copied from words that were left alone. The all-zero and all-one masks cover the extremes. One run changes the mask to its complement and pulses sync mid-copy; this shows whether the mask is held and whether a late sync restarts or stretches the sweep. Count sets that total 8, 9 and a single field of 9 locate the legality boundary and the field positions.

// File: rtl/cbc_pkg.sv
// Package: shared constants and types for the coefficient bank copy engine.
// Assumes a fixed set of eight banks and four processing stages.
package cbc_pkg;
    localparam int NUM_BANKS  = 8;
    localparam int NUM_STAGES = 4;
    localparam int CNT_W      = 4;
    localparam int BANK_LIMIT = 8;
    typedef logic [NUM_BANKS-1:0] bank_mask_t;
endpackage

// File: rtl/cbc_stage_check.sv
// Module: cbc_stage_check
// Adds up the per-stage bank counts and flags a sum above the bank limit.
// Assumes the counts are packed, stage s at [s*CNT_W +: CNT_W], unsigned.
module cbc_stage_check #(
    parameter int NUM_STAGES = 4,
    parameter int CNT_W      = 4,
    parameter int LIMIT      = 8
) (
    input  logic [NUM_STAGES*CNT_W-1:0] counts_i,
    output logic                        over_o
);
    localparam int SUM_W = CNT_W + $clog2(NUM_STAGES) + 1;

    logic [SUM_W-1:0] psum [NUM_STAGES+1];

    assign psum[0] = '0;

    // Chain of partial sums, one adder per stage field.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_sum
        assign psum[s+1] = psum[s] + SUM_W'(counts_i[s*CNT_W +: CNT_W]);
    end

    assign over_o = psum[NUM_STAGES] > SUM_W'(LIMIT);
endmodule

// File: rtl/cbc_read_seq.sv
// Module: cbc_read_seq
// Issues shadow read addresses 0..DEPTH-1, one per cycle, after a start.
// Assumes start_i is only raised while the sequencer is idle.
module cbc_read_seq #(
    parameter int DEPTH = 768,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Address counter: loads zero on start, stops after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en_o   <= 1'b0;
            rd_addr_o <= '0;
        end else if (start_i) begin
            rd_en_o   <= 1'b1;
            rd_addr_o <= '0;
        end else if (rd_en_o) begin
            if (rd_addr_o == LAST) begin
                rd_en_o <= 1'b0;
            end else begin
                rd_addr_o <= rd_addr_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cbc_write_stage.sv
// Module: cbc_write_stage
// Aligns the write address with shadow read data (one cycle latency) and
// fans the write out to the banks selected by the held mask.
// Assumes mask_i stays constant for the whole copy.
module cbc_write_stage #(
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 768,
    parameter int AW        = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en_i,
    input  logic [AW-1:0]        rd_addr_i,
    input  logic [DATA_W-1:0]    rd_data_i,
    input  logic [NUM_BANKS-1:0] mask_i,
    output logic [NUM_BANKS-1:0] wr_en_o,
    output logic [AW-1:0]        wr_addr_o,
    output logic [DATA_W-1:0]    wr_data_o,
    output logic                 last_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic wr_valid;

    // Delay the read request by one cycle to meet the returning data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_addr_o <= '0;
        end else begin
            wr_valid  <= rd_en_i;
            wr_addr_o <= rd_addr_i;
        end
    end

    // Per-bank write enable gated by that bank's mask bit.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_en_o[b] = wr_valid & mask_i[b];
    end

    assign wr_data_o = rd_data_i;
    assign last_o    = wr_valid && (wr_addr_o == LAST);
endmodule

// File: rtl/cbc_copy_engine.sv
// Module: cbc_copy_engine (top)
// Sync-triggered copy of the whole shadow memory into the masked subset of
// the working banks. Refuses a sync when the stage counts exceed the limit.
// Assumes a shadow memory with one cycle of read latency.
module cbc_copy_engine
    import cbc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 768,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sync,
    input  logic [NUM_BANKS-1:0]         bank_mask,
    input  logic [NUM_STAGES*CNT_W-1:0]  stage_cnt,
    output logic                         shadow_rd_en,
    output logic [AW-1:0]                shadow_rd_addr,
    input  logic [DATA_W-1:0]            shadow_rd_data,
    output logic [NUM_BANKS-1:0]         bank_wr_en,
    output logic [AW-1:0]                bank_wr_addr,
    output logic [DATA_W-1:0]            bank_wr_data,
    output logic                         busy,
    output logic                         done,
    output logic                         cfg_err
);
    logic       over;
    logic       start;
    logic       last_wr;
    bank_mask_t mask_q;

    cbc_stage_check #(
        .NUM_STAGES(NUM_STAGES), .CNT_W(CNT_W), .LIMIT(BANK_LIMIT)
    ) u_check (
        .counts_i(stage_cnt), .over_o(over)
    );

    assign start = sync && !busy && !over;

    cbc_read_seq #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rd_en_o(shadow_rd_en), .rd_addr_o(shadow_rd_addr)
    );

    cbc_write_stage #(
        .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .rd_en_i(shadow_rd_en), .rd_addr_i(shadow_rd_addr),
        .rd_data_i(shadow_rd_data), .mask_i(mask_q),
        .wr_en_o(bank_wr_en), .wr_addr_o(bank_wr_addr),
        .wr_data_o(bank_wr_data), .last_o(last_wr)
    );

    // Copy control: busy window, held mask, done pulse and config error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            cfg_err <= 1'b0;
            mask_q  <= '0;
        end else begin
            done <= last_wr;
            if (start) begin
                busy    <= 1'b1;
                mask_q  <= bank_mask;
                cfg_err <= 1'b0;
            end else if (last_wr) begin
                busy <= 1'b0;
            end
            if (sync && !busy && over) begin
                cfg_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cbc_copy_engine_chk.sv
// Module: cbc_copy_engine_chk
// Port-level temporal checks for the copy engine, bound to the top module.
module cbc_copy_engine_chk #(
    parameter int NUM_BANKS = 8,
    parameter int AW        = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shadow_rd_en,
    input logic [AW-1:0]        shadow_rd_addr,
    input logic [NUM_BANKS-1:0] bank_wr_en,
    input logic [AW-1:0]        bank_wr_addr,
    input logic                 busy,
    input logic                 done,
    input logic                 cfg_err
);
    AST_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_rd_en |-> busy);  // R2
    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_rd_en && $past(shadow_rd_en)) |-> shadow_rd_addr == AW'($past(shadow_rd_addr) + 1'b1));  // R2
    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bank_wr_en) && $past(|bank_wr_en)) |-> bank_wr_addr == AW'($past(bank_wr_addr) + 1'b1));  // R3
    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_wr_en) |-> busy);  // R4
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bank_wr_en) && $past(|bank_wr_en)) |-> bank_wr_en == $past(bank_wr_en));  // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));  // R8
    AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !cfg_err);  // R9
endmodule

bind cbc_copy_engine cbc_copy_engine_chk #(.NUM_BANKS(cbc_pkg::NUM_BANKS), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .shadow_rd_en(shadow_rd_en),
    .shadow_rd_addr(shadow_rd_addr), .bank_wr_en(bank_wr_en),
    .bank_wr_addr(bank_wr_addr), .busy(busy), .done(done), .cfg_err(cfg_err)
);

// File: tb/cbc_copy_engine_tb_top.sv
module cbc_copy_engine_tb_top;
    localparam int DEPTH = 768;
    localparam int DW    = 16;
    localparam int AW    = 10;
    localparam int NB    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync = 1'b0;
    logic [NB-1:0] bank_mask = '0;
    logic [15:0]   stage_cnt = '0;
    logic          shadow_rd_en;
    logic [AW-1:0] shadow_rd_addr;
    logic [DW-1:0] shadow_rd_data;
    logic [NB-1:0] bank_wr_en;
    logic [AW-1:0] bank_wr_addr;
    logic [DW-1:0] bank_wr_data;
    logic          busy, done, cfg_err;

    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] bank_mem [NB][DEPTH];
    logic [DW-1:0] exp_mem [NB][DEPTH];

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    cbc_copy_engine #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync(sync), .bank_mask(bank_mask),
        .stage_cnt(stage_cnt), .shadow_rd_en(shadow_rd_en),
        .shadow_rd_addr(shadow_rd_addr), .shadow_rd_data(shadow_rd_data),
        .bank_wr_en(bank_wr_en), .bank_wr_addr(bank_wr_addr),
        .bank_wr_data(bank_wr_data), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    // Shadow memory model with one cycle of read latency, and the banks.
    always @(posedge clk) begin
        if (shadow_rd_en) shadow_rd_data <= shadow[shadow_rd_addr];
        for (int b = 0; b < NB; b++)
            if (bank_wr_en[b]) bank_mem[b][bank_wr_addr] <= bank_wr_data;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pack(input int s0, input int s1, input int s2, input int s3);
        return {4'(s3), 4'(s2), 4'(s1), 4'(s0)};  // R10 stage s at [4s+3:4s]
    endfunction

    task automatic fill_shadow();
        for (int w = 0; w < DEPTH; w++) shadow[w] = DW'($urandom);
    endtask

    // One sync request; checks busy/done/err timing and every bank word.
    task automatic run_copy(input logic [7:0] m, input logic [15:0] cnt,
                            input bit go, input bit disturb, input string tag);
        int busy_n = 0;
        int done_n = 0;
        int done_idx = -1;
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < DEPTH; w++)
                exp_mem[b][w] = (go && m[b]) ? shadow[w] : bank_mem[b][w];
        @(negedge clk);
        bank_mask = m; stage_cnt = cnt; sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        for (int i = 0; i < 790; i++) begin
            if (busy) busy_n++;
            if (done) begin done_n++; done_idx = i; end
            if (disturb && i == 100) begin sync = 1'b1; bank_mask = ~m; end
            if (disturb && i == 101) sync = 1'b0;
            @(negedge clk);
        end
        if (go) begin
            check(busy_n == DEPTH + 1, disturb ? "R6 busy length with late sync" : "R7 busy length", busy_n, DEPTH + 1);
            check(done_n == 1, "R8 done width", done_n, 1);
            check(done_idx == DEPTH + 1, "R8 done position", done_idx, DEPTH + 1);
            check(cfg_err == 1'b0, "R9 err cleared", int'(cfg_err), 0);
        end else begin
            check(busy_n == 0, "R9 refused sync busy", busy_n, 0);
            check(done_n == 0, "R9 refused sync done", done_n, 0);
            check(cfg_err == 1'b1, "R9 err raised", int'(cfg_err), 1);
        end
        for (int b = 0; b < NB; b++) begin
            int bad = -1;
            for (int w = DEPTH - 1; w >= 0; w--)
                if (bank_mem[b][w] !== exp_mem[b][w]) bad = w;
            if (bad < 0)
                check(1'b1, "R3", 0, 0);
            else if (go && m[b])
                check(1'b0, {tag, " R3 selected bank word"}, int'(bank_mem[b][bad]), int'(exp_mem[b][bad]));
            else
                check(1'b0, {tag, disturb ? " R5 unselected bank word" : " R4 unselected bank word"},
                      int'(bank_mem[b][bad]), int'(exp_mem[b][bad]));
        end
        bank_mask = '0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        fill_shadow();
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < DEPTH; w++) bank_mem[b][w] = DW'(b * 4096 + w);
        repeat (3) @(negedge clk);
        check(!busy && !done && !cfg_err, "R1 reset flags", int'({busy, done, cfg_err}), 0);
        check(bank_wr_en == '0 && !shadow_rd_en, "R1 reset enables", int'(bank_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cfg_err && !shadow_rd_en, "R1 after reset", int'(busy), 0);

        run_copy(8'hA5, pack(2, 2, 2, 2), 1'b1, 1'b0, "R2 sum8");
        fill_shadow();
        run_copy(8'h3C, pack(3, 3, 2, 1), 1'b0, 1'b0, "R9 sum9");
        run_copy(8'hFF, pack(0, 0, 0, 9), 1'b0, 1'b0, "R10 field3");
        run_copy(8'hFF, pack(9, 0, 0, 0), 1'b0, 1'b0, "R10 field0");
        run_copy(8'h00, pack(1, 1, 1, 1), 1'b1, 1'b0, "R4 mask0");
        run_copy(8'h96, pack(4, 0, 4, 0), 1'b1, 1'b1, "R5 R6 disturb");
        for (int k = 0; k < 3; k++) begin
            fill_shadow();
            run_copy(8'($urandom), pack($urandom_range(0, 2), $urandom_range(0, 2),
                     $urandom_range(0, 2), $urandom_range(0, 2)), 1'b1, 1'b0, "R3 random");
        end
        fill_shadow();
        run_copy(8'hFF, pack(8, 0, 0, 0), 1'b1, 1'b0, "R3 all banks");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule